// File: doc/BRIEF.md
# Set Replacement Way Selector

This block picks the way of an E-way set-associative cache that a fill will overwrite. A tag lookup reports the set it is working on, a hit strobe carrying the way that matched, and a replacement strobe when a fill is about to claim a way. The block answers with the victim way for the set currently presented on its index input. The tag and data arrays and the fill sequencing live elsewhere. The block holds only the bookkeeping needed to choose the victim.

A parameter fixes the replacement policy at build time, and all three policies use the same ports. In first-in-first-out mode every set has its own modulo-E pointer. In random mode a single modulo-E counter serves every set, and a second parameter chooses whether it advances every clock, on every reference, or on every replacement. In least-recently-used mode every set keeps a complete usage order of its ways, stored as E entries of log2(E) bits each. Only the state of the selected policy is built.

The victim output is combinational from the stored state of the indexed set. A fill on that set takes effect at the next rising clock edge. When a hit and a replacement arrive in the same cycle, the replacement is applied and the hit is dropped.

Top module: `repl_way_selector`

## Requirements
- R1: After reset the victim is way 0 for every set under every policy. Before the first clock edge the victim follows the index input.
- R2: First-in-first-out mode (POLICY=0): a replacement on set s moves that set's victim to (v+1) mod E, where v is its current victim. All other sets keep their victim.
- R3: First-in-first-out mode: a hit on set s, with no replacement in the same cycle, leaves the victim of every set unchanged.
- R4: Random mode (POLICY=1): every set shows the same victim, namely the shared counter. A replacement on one set therefore also moves the victim seen by every other set.
- R5: Random mode: the shared counter starts at 0 and advances by one modulo E as set by RAND_ADVANCE: 0 advances it every clock cycle, 1 on any cycle with a hit or a replacement, and 2 only on a replacement cycle.
- R6: Least-recently-used mode (POLICY=2): the victim of a set is the way referenced longest ago. Reset counts way 0 as oldest and way E-1 as newest, and a hit makes the hit way the newest.
- R7: Least-recently-used mode: a replacement makes the victim way the newest of its set. The next victim of that set is the way that was second oldest.
- R8: When a hit and a replacement are asserted in the same cycle, only the replacement updates state. The hit way is not made newest and does not count as a reference.
- R9: The victim output reflects the index input within the same cycle, with no clock edge needed.
- R10: When E is not a power of two, the first-in-first-out pointer wraps from E-1 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| setIdx | input | $clog2(NUM_SETS) | Set currently being looked up or filled |
| hitPulse | input | 1 | One-cycle strobe: the lookup hit in setIdx |
| hitWay | input | $clog2(NUM_WAYS) | Way that hit; used only in least-recently-used mode |
| replPulse | input | 1 | One-cycle strobe: the victim of setIdx is being filled now |
| victimWay | output | $clog2(NUM_WAYS) | Way to evict for setIdx |

## Verification
A stale or corrupted entry in a set's state shows up at victimWay in the same cycle that set is next indexed. A wrong update therefore surfaces at the first lookup of that set after the faulty edge. The bench tracks every set of six configurations in parallel with its own models: pointers, a shared counter, and usage timestamps. It compares each victim before every clock edge. A wrong wrap, a counter that advances in the wrong mode, a hit that leaks through alongside a replacement, or a broken usage order all change a victim within a few steps of the stimulus. Replacement order and usage order only become visible after several fills on the same set, so the stimulus repeats fills and hits on the same sets.

// File: rtl/repl_sel_pkg.sv
package repl_sel_pkg;
  localparam int POL_FIFO   = 0;
  localparam int POL_RANDOM = 1;
  localparam int POL_LRU    = 2;

  localparam int ADV_CYCLE = 0;
  localparam int ADV_REF   = 1;
  localparam int ADV_REPL  = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic fifoStep;     // advance the indexed set's pointer
    logic randStep;     // advance the shared counter
    logic lruTouch;     // move a way of the indexed set to newest
    logic touchVictim;  // the way to touch is the current victim
  } selStrobesT;
endpackage

// File: rtl/way_sel_ctrl.sv
module way_sel_ctrl
  import repl_sel_pkg::*;
#(
  parameter int POLICY       = POL_LRU,
  parameter int RAND_ADVANCE = ADV_REPL
) (
  input  logic       hitPulse,
  input  logic       replPulse,
  output selStrobesT strobes
);
  logic anyRef;
  logic randEvent;

  assign anyRef = hitPulse | replPulse;

  generate
    if (RAND_ADVANCE == ADV_CYCLE) begin : g_advCycle
      assign randEvent = 1'b1;
    end else if (RAND_ADVANCE == ADV_REF) begin : g_advRef
      assign randEvent = anyRef;
    end else begin : g_advRepl
      assign randEvent = replPulse;
    end
  endgenerate

  always_comb begin
    strobes             = '0;
    strobes.fifoStep    = (POLICY == POL_FIFO) && replPulse;
    strobes.randStep    = (POLICY == POL_RANDOM) && randEvent;
    strobes.lruTouch    = (POLICY == POL_LRU) && anyRef;
    // a replacement wins over a hit in the same cycle (R8)
    strobes.touchVictim = replPulse;
  end
endmodule

// File: rtl/way_sel_dp.sv
module way_sel_dp
  import repl_sel_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 8,
  parameter int POLICY   = POL_LRU,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SET_W-1:0] setIdx,
  input  logic [WAY_W-1:0] hitWay,
  input  selStrobesT       strobes,
  output logic [WAY_W-1:0] victimWay
);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);

  generate
    if (POLICY == POL_FIFO) begin : g_fifo
      logic [WAY_W-1:0] fifoPtr [NUM_SETS];
      logic unusedBits;
      assign unusedBits = ^{hitWay, strobes.randStep, strobes.lruTouch, strobes.touchVictim};

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int s = 0; s < NUM_SETS; s++) fifoPtr[s] <= '0;
        end else if (strobes.fifoStep) begin
          fifoPtr[setIdx] <= (fifoPtr[setIdx] == LAST_WAY) ? '0 : fifoPtr[setIdx] + 1'b1;
        end
      end
      assign victimWay = fifoPtr[setIdx];

      // R10: pointer never leaves 0..E-1 even for non power-of-two E
      a_r10_ptr_in_range: assert property (@(posedge clk) disable iff (!rstN)
        int'(fifoPtr[setIdx]) < NUM_WAYS);
    end else if (POLICY == POL_RANDOM) begin : g_rand
      logic [WAY_W-1:0] randCnt;
      logic unusedBits;
      assign unusedBits = ^{setIdx, hitWay, strobes.fifoStep, strobes.lruTouch, strobes.touchVictim};

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) randCnt <= '0;
        else if (strobes.randStep) randCnt <= (randCnt == LAST_WAY) ? '0 : randCnt + 1'b1;
      end
      assign victimWay = randCnt;

      a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
        int'(randCnt) < NUM_WAYS);
    end else begin : g_lru
      // order[s][0] is oldest, order[s][NUM_WAYS-1] is newest
      logic [WAY_W-1:0] order [NUM_SETS][NUM_WAYS];
      logic [WAY_W-1:0] curRow  [NUM_WAYS];
      logic [WAY_W-1:0] nextRow [NUM_WAYS];
      logic [WAY_W-1:0] touchWay;
      logic [WAY_W-1:0] touchPos;
      logic [NUM_WAYS-1:0] seenMask;
      logic unusedBits;
      assign unusedBits = ^{strobes.fifoStep, strobes.randStep};

      always_comb begin
        for (int i = 0; i < NUM_WAYS; i++) curRow[i] = order[setIdx][i];
        touchWay = strobes.touchVictim ? curRow[0] : hitWay;
        touchPos = '0;
        seenMask = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
          if (curRow[i] == touchWay) touchPos = WAY_W'(i);
          seenMask[curRow[i]] = 1'b1;
        end
        for (int i = 0; i < NUM_WAYS; i++) begin
          if (i < int'(touchPos)) nextRow[i] = curRow[i];
          else if (i < NUM_WAYS - 1) nextRow[i] = curRow[(i < NUM_WAYS - 1) ? i + 1 : i];
          else nextRow[i] = touchWay;
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int s = 0; s < NUM_SETS; s++)
            for (int i = 0; i < NUM_WAYS; i++) order[s][i] <= WAY_W'(i);
        end else if (strobes.lruTouch) begin
          for (int i = 0; i < NUM_WAYS; i++) order[setIdx][i] <= nextRow[i];
        end
      end
      assign victimWay = curRow[0];

      // R6: the indexed set always holds a full ordering of all ways
      a_r6_order_is_permutation: assert property (@(posedge clk) disable iff (!rstN)
        seenMask == {NUM_WAYS{1'b1}});
    end
  endgenerate
endmodule

// File: rtl/repl_way_selector.sv
module repl_way_selector
  import repl_sel_pkg::*;
#(
  parameter int NUM_WAYS     = 4,
  parameter int NUM_SETS     = 8,
  parameter int POLICY       = POL_LRU,
  parameter int RAND_ADVANCE = ADV_REPL,
  localparam int WAY_W       = $clog2(NUM_WAYS),
  localparam int SET_W       = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SET_W-1:0] setIdx,
  input  logic             hitPulse,
  input  logic [WAY_W-1:0] hitWay,
  input  logic             replPulse,
  output logic [WAY_W-1:0] victimWay
);
  selStrobesT strobes;

  way_sel_ctrl #(.POLICY(POLICY), .RAND_ADVANCE(RAND_ADVANCE)) u_ctrl (
    .hitPulse (hitPulse),
    .replPulse(replPulse),
    .strobes  (strobes)
  );

  way_sel_dp #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .POLICY(POLICY)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .setIdx   (setIdx),
    .hitWay   (hitWay),
    .strobes  (strobes),
    .victimWay(victimWay)
  );

  // R7: a fill always moves the victim of the filled set away from the filled way
  a_r7_fill_moves_victim: assert property (@(posedge clk) disable iff (!rstN)
    replPulse |=> (setIdx != $past(setIdx)) || (victimWay != $past(victimWay)));

  generate
    if (POLICY == POL_FIFO) begin : g_chkFifo
      a_r2_fifo_steps_by_one: assert property (@(posedge clk) disable iff (!rstN)
        replPulse |=> (setIdx != $past(setIdx)) ||
          (int'(victimWay) == ((int'($past(victimWay)) + 1) % NUM_WAYS)));
      a_r3_hit_keeps_victim: assert property (@(posedge clk) disable iff (!rstN)
        !replPulse |=> (setIdx != $past(setIdx)) || $stable(victimWay));
    end else if (POLICY == POL_RANDOM && RAND_ADVANCE == ADV_REPL) begin : g_chkRand
      a_r5_idle_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
        !replPulse |=> $stable(victimWay));
    end else if (POLICY == POL_LRU) begin : g_chkLru
      a_r6_hit_not_victim: assert property (@(posedge clk) disable iff (!rstN)
        (hitPulse && !replPulse) |=> (setIdx != $past(setIdx)) ||
          (victimWay != $past(hitWay)));
      a_r6_idle_keeps_victim: assert property (@(posedge clk) disable iff (!rstN)
        (!hitPulse && !replPulse) |=> (setIdx != $past(setIdx)) || $stable(victimWay));
    end
  endgenerate
endmodule

// File: tb/tb_repl_way_selector.sv
`timescale 1ns/1ps
module tb_repl_way_selector;
  localparam int CLK_PERIOD = 20;
  localparam int SETS = 8;
  localparam int WAYS = 4;
  localparam int WATCHDOG = 5000;
  localparam int N_STIM = 25;
  // entry: {set[2:0], hit, hitWay[1:0], repl}
  localparam logic [6:0] STIM [N_STIM] = '{
    {3'd0,1'b0,2'd0,1'b1}, {3'd0,1'b0,2'd0,1'b1}, {3'd0,1'b1,2'd1,1'b0},
    {3'd0,1'b0,2'd0,1'b1}, {3'd0,1'b0,2'd0,1'b1}, {3'd0,1'b1,2'd3,1'b0},
    {3'd0,1'b0,2'd0,1'b0}, {3'd3,1'b1,2'd2,1'b0}, {3'd3,1'b1,2'd0,1'b0},
    {3'd3,1'b0,2'd0,1'b1}, {3'd3,1'b1,2'd1,1'b0}, {3'd3,1'b0,2'd0,1'b1},
    {3'd1,1'b0,2'd0,1'b1}, {3'd1,1'b1,2'd3,1'b1}, {3'd1,1'b0,2'd0,1'b1},
    {3'd0,1'b1,2'd2,1'b0}, {3'd0,1'b0,2'd0,1'b1}, {3'd7,1'b1,2'd3,1'b0},
    {3'd7,1'b1,2'd2,1'b0}, {3'd7,1'b1,2'd1,1'b0}, {3'd7,1'b0,2'd0,1'b1},
    {3'd7,1'b0,2'd0,1'b0}, {3'd2,1'b1,2'd0,1'b0}, {3'd2,1'b0,2'd0,1'b1},
    {3'd2,1'b0,2'd0,1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] setIdx = '0;
  logic hitPulse = 1'b0;
  logic [1:0] hitWay = '0;
  logic replPulse = 1'b0;
  logic [1:0] vLru, vFifo, vFifo3, vRnd0, vRnd1, vRnd2;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // bench models
  int fifoM [SETS];
  int fifo3M [SETS];
  int rndM [3];
  int stamp [SETS][WAYS];
  int tick = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  repl_way_selector #(.NUM_WAYS(4), .NUM_SETS(8), .POLICY(2)) dut (
    .clk(clk), .rstN(rstN), .setIdx(setIdx), .hitPulse(hitPulse), .hitWay(hitWay),
    .replPulse(replPulse), .victimWay(vLru));
  repl_way_selector #(.NUM_WAYS(4), .NUM_SETS(8), .POLICY(0)) dutFifo (
    .clk(clk), .rstN(rstN), .setIdx(setIdx), .hitPulse(hitPulse), .hitWay(hitWay),
    .replPulse(replPulse), .victimWay(vFifo));
  repl_way_selector #(.NUM_WAYS(3), .NUM_SETS(8), .POLICY(0)) dutFifo3 (
    .clk(clk), .rstN(rstN), .setIdx(setIdx), .hitPulse(hitPulse), .hitWay(hitWay),
    .replPulse(replPulse), .victimWay(vFifo3));
  repl_way_selector #(.NUM_WAYS(4), .NUM_SETS(8), .POLICY(1), .RAND_ADVANCE(0)) dutRnd0 (
    .clk(clk), .rstN(rstN), .setIdx(setIdx), .hitPulse(hitPulse), .hitWay(hitWay),
    .replPulse(replPulse), .victimWay(vRnd0));
  repl_way_selector #(.NUM_WAYS(4), .NUM_SETS(8), .POLICY(1), .RAND_ADVANCE(1)) dutRnd1 (
    .clk(clk), .rstN(rstN), .setIdx(setIdx), .hitPulse(hitPulse), .hitWay(hitWay),
    .replPulse(replPulse), .victimWay(vRnd1));
  repl_way_selector #(.NUM_WAYS(4), .NUM_SETS(8), .POLICY(1), .RAND_ADVANCE(2)) dutRnd2 (
    .clk(clk), .rstN(rstN), .setIdx(setIdx), .hitPulse(hitPulse), .hitWay(hitWay),
    .replPulse(replPulse), .victimWay(vRnd2));

  function automatic int lruVictim(int s);
    int best = 0;
    for (int w = 1; w < WAYS; w++) if (stamp[s][w] < stamp[s][best]) best = w;
    return best;
  endfunction

  initial begin
    for (int s = 0; s < SETS; s++) begin
      fifoM[s] = 0;
      fifo3M[s] = 0;
      for (int w = 0; w < WAYS; w++) stamp[s][w] = w - WAYS;  // way 0 oldest
    end
    for (int k = 0; k < 3; k++) rndM[k] = 0;
  end

  // models follow the rules in the requirements
  always @(posedge clk) begin
    if (rstN) begin
      int s;
      s = int'(setIdx);
      tick = tick + 1;
      rndM[0] = (rndM[0] + 1) % WAYS;                                   // R5 mode 0
      if (hitPulse || replPulse) rndM[1] = (rndM[1] + 1) % WAYS;        // R5 mode 1
      if (replPulse) rndM[2] = (rndM[2] + 1) % WAYS;                    // R5 mode 2
      if (replPulse) begin
        fifoM[s] = (fifoM[s] + 1) % 4;                                  // R2
        fifo3M[s] = (fifo3M[s] + 1) % 3;                                // R10
        stamp[s][lruVictim(s)] = tick;                                  // R7, R8
      end else if (hitPulse) begin
        stamp[s][int'(hitWay)] = tick;                                  // R6
      end
    end
  end

  task automatic chk(string tag, string name, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d (set %0d)", tag, name, got, exp, setIdx);
    end
  endtask

  task automatic checkAll(string tag);
    int s;
    s = int'(setIdx);
    chk(tag, "lru R6",        int'(vLru),   lruVictim(s));
    chk(tag, "fifo4 R2",      int'(vFifo),  fifoM[s]);
    chk(tag, "fifo3 R10",     int'(vFifo3), fifo3M[s]);
    chk(tag, "rand-cycle R5", int'(vRnd0),  rndM[0]);
    chk(tag, "rand-ref R5",   int'(vRnd1),  rndM[1]);
    chk(tag, "rand-repl R4",  int'(vRnd2),  rndM[2]);
  endtask

  task automatic step(string tag, int s, bit h, int w, bit r);
    @(negedge clk);
    setIdx = 3'(s);
    hitPulse = h;
    hitWay = 2'(w);
    replPulse = r;
    #1;
    checkAll(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 and R9: before any edge every set shows way 0, index changes seen at once
    for (int s = 0; s < SETS; s++) begin
      setIdx = 3'(s);
      #1;
      chk("R1", "lru", int'(vLru), 0);
      chk("R1", "fifo4", int'(vFifo), 0);
      chk("R9", "rand-cycle", int'(vRnd0), 0);
    end

    // vector table walk
    for (int i = 0; i < N_STIM; i++) begin
      step("table", int'(STIM[i][6:4]), STIM[i][3], int'(STIM[i][2:1]), STIM[i][0]);
    end

    // R3: hits alone leave the first-in-first-out pointers alone
    step("R3", 4, 1'b1, 2, 1'b0);
    step("R3", 4, 1'b1, 0, 1'b0);
    step("R3", 4, 1'b0, 0, 1'b0);
    chk("R3", "fifo4 set4", int'(vFifo), 0);

    // R4: a fill on set 5 moves the shared victim seen through set 2
    step("R4", 5, 1'b0, 0, 1'b1);
    step("R4", 2, 1'b0, 0, 1'b0);

    // R8: hit together with a fill on fresh set 6; only the fill counts
    step("R8", 6, 1'b1, 2, 1'b1);
    step("R8", 6, 1'b0, 0, 1'b1);
    step("R8", 6, 1'b0, 0, 1'b0);
    chk("R8", "lru set6", int'(vLru), 2);

    // R9: index flip without a clock edge
    @(negedge clk);
    hitPulse = 1'b0;
    replPulse = 1'b0;
    setIdx = 3'd0;
    #1;
    checkAll("R9");
    setIdx = 3'd6;
    #1;
    checkAll("R9");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule